// File: doc/BRIEF.md
# Two-Rail Avionics Word Transmitter

This block takes 32-bit avionics data words from a host, delivered as two 16-bit half-word writes, and keeps up to 32 of them in order in a queue. A serializer then sends each queued word on a pair of complementary return-to-zero lines, one bit per bit period. Bit one of the word goes out first. Before a word is sent, its most significant bit can be replaced with an odd or even parity bit, or left as it was loaded.

The bit period is either 10 or 80 system clocks. A rate select input chooses between them, and its value is sampled when each word starts. Every word is followed by at least four bit periods with both lines idle. An enable input decides whether a new word may start. A word that is already on the line always finishes.

Three flags report the queue state to the host: a ready flag when the queue is empty, a flag that stays high while fewer than half the slots are used, and a full flag. Once the queue is full, further writes are dropped.

Top module: `a429_tx_serializer`

## Requirements
- R1: A pulse on `load_lo` stores `din` as word bits [15:0]. A following pulse on `load_hi` takes `din` as bits [31:16] and places the combined word in the next free queue slot.
- R2: The queue holds up to 32 words and sends them in the order they were written.
- R3: With 32 words queued, `full_flag` is 1 and a `load_hi` pulse adds nothing. The dropped word is never transmitted.
- R4: With `parity_en`=1, transmitted bit 32 (word bit 31) is replaced so that the 32 sent bits hold an odd number of ones when `parity_even`=0, and an even number of ones when `parity_even`=1.
- R5: With `parity_en`=0, all 32 loaded bits are transmitted unchanged.
- R6: One bit period lasts 10 clocks when `rate_slow`=0 and 80 clocks when `rate_slow`=1.
- R7: During the first half of each bit period, exactly one line is high: `line_hi` for a one, `line_lo` for a zero. During the second half, both lines are low. The two lines are never high together.
- R8: After the last bit of a word, both lines stay low for at least 4 bit periods before the next word starts.
- R9: A new word starts only while `tx_enable`=1 and the queue is not empty. Dropping `tx_enable` during a word does not cut that word short.
- R10: Word bit 0 is transmitted first and word bit 31 last.
- R11: `tx_ready` is 1 exactly when the queue is empty. `half_flag` is 1 while fewer than 16 words are queued.
- R12: After reset the queue is empty: `tx_ready`=1, `half_flag`=1, `full_flag`=0, and both lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_lo | input | 1 | One-cycle strobe that captures the low half-word |
| load_hi | input | 1 | One-cycle strobe that captures the high half-word and queues the word |
| din | input | 16 | Half-word data from the host |
| parity_en | input | 1 | 1: replace bit 32 with parity; 0: send bit 32 as loaded |
| parity_even | input | 1 | Parity sense: 0 odd, 1 even |
| rate_slow | input | 1 | 0: 10 clocks per bit; 1: 80 clocks per bit |
| tx_enable | input | 1 | Allows a new word to start |
| line_hi | output | 1 | Return-to-zero line for one bits |
| line_lo | output | 1 | Return-to-zero line for zero bits |
| tx_ready | output | 1 | Queue empty |
| half_flag | output | 1 | Fewer than half the slots in use |
| full_flag | output | 1 | Queue full |

## Verification
The bench uses the default parameters: 32 slots, dividers of 10 and 80, and a 4-bit gap. With these values, filling the queue past its half point and up to the full point takes only a few dozen writes, so the drop-on-full case and the full in-order drain are both covered. The slow divider is used for one word, which checks that the bit period and the half-period null are timed from the rate sampled when that word started. The fast divider keeps the 32-word drain well within the cycle budget.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_GAP  = 2'd2
    } tx_state_e;
endpackage

// File: rtl/tx_word_queue.sv
module tx_word_queue #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_lo,
    input  logic                  load_hi,
    input  logic [HALF_W-1:0]     din,
    input  logic                  pop,
    output logic [2*HALF_W-1:0]   head,
    output logic                  empty,
    output logic                  below_half,
    output logic                  full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DEPTH / 2);

    typedef struct packed {
        logic [HALF_W-1:0] lo;
        logic [PTR_W-1:0]  wr_ptr;
        logic [PTR_W-1:0]  rd_ptr;
        logic [CNT_W-1:0]  count;
    } q_state_t;

    q_state_t st_q, st_d;
    logic [2*HALF_W-1:0] mem_q [DEPTH];
    logic push;

    assign push = load_hi && (st_q.count != CNT_FULL);

    always_comb begin
        st_d = st_q;
        if (load_lo) begin
            st_d.lo = din;
        end
        if (push) begin
            st_d.wr_ptr = (st_q.wr_ptr == PTR_LAST) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == PTR_LAST) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[st_q.wr_ptr] <= {din, st_q.lo};
        end
    end

    assign head       = mem_q[st_q.rd_ptr];
    assign empty      = (st_q.count == '0);
    assign below_half = (st_q.count < CNT_HALF);
    assign full       = (st_q.count == CNT_FULL);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_FULL); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && load_hi && !pop) |=> full); // R3
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int unsigned DIV_FAST = 10,
    parameter int unsigned DIV_SLOW = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic rate_slow,
    output logic first_half,
    output logic bit_end
);
    localparam int unsigned DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int unsigned CW = $clog2(DIV_MAX);
    localparam logic [CW-1:0] LIM_FAST  = CW'(DIV_FAST - 1);
    localparam logic [CW-1:0] LIM_SLOW  = CW'(DIV_SLOW - 1);
    localparam logic [CW-1:0] HALF_FAST = CW'(DIV_FAST / 2);
    localparam logic [CW-1:0] HALF_SLOW = CW'(DIV_SLOW / 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          slow;
    } tm_state_t;

    tm_state_t st_q, st_d;
    logic [CW-1:0] lim;

    assign lim = st_q.slow ? LIM_SLOW : LIM_FAST;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt  = '0;
            st_d.slow = rate_slow;
        end else if (st_q.cnt == lim) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign first_half = st_q.cnt < (st_q.slow ? HALF_SLOW : HALF_FAST);
    assign bit_end    = (st_q.cnt == lim);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DIV_MAX - 1)); // R6
    AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(st_q.slow)); // R6
endmodule

// File: rtl/tx_line_shifter.sv
module tx_line_shifter
    import a429_tx_pkg::*;
#(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned GAP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              q_empty,
    input  logic [WORD_W-1:0] q_head,
    input  logic              parity_en,
    input  logic              parity_even,
    input  logic              first_half,
    input  logic              bit_end,
    output logic              q_pop,
    output logic              timer_restart,
    output logic              line_hi,
    output logic              line_lo
);
    localparam int unsigned CMAX = (WORD_W > GAP_BITS) ? WORD_W : GAP_BITS;
    localparam int unsigned BC_W = $clog2(CMAX);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);
    localparam logic [BC_W-1:0] LAST_GAP = BC_W'(GAP_BITS - 1);

    typedef struct packed {
        tx_state_e         state;
        logic [WORD_W-1:0] shift;
        logic [BC_W-1:0]   bit_cnt;
    } sh_state_t;

    sh_state_t st_q, st_d;
    logic start;
    logic top_bit;

    assign start = (st_q.state == TX_IDLE) && tx_enable && !q_empty;

    always_comb begin
        if (!parity_en) begin
            top_bit = q_head[WORD_W-1];
        end else if (parity_even) begin
            top_bit = ^q_head[WORD_W-2:0];
        end else begin
            top_bit = ~^q_head[WORD_W-2:0];
        end
    end

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            TX_IDLE: begin
                if (start) begin
                    st_d.state   = TX_SEND;
                    st_d.shift   = {top_bit, q_head[WORD_W-2:0]};
                    st_d.bit_cnt = '0;
                end
            end
            TX_SEND: begin
                if (bit_end) begin
                    st_d.shift   = st_q.shift >> 1;
                    if (st_q.bit_cnt == LAST_BIT) begin
                        st_d.state   = TX_GAP;
                        st_d.bit_cnt = '0;
                    end else begin
                        st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                    end
                end
            end
            TX_GAP: begin
                if (bit_end) begin
                    if (st_q.bit_cnt == LAST_GAP) begin
                        st_d.state   = TX_IDLE;
                        st_d.bit_cnt = '0;
                    end else begin
                        st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                    end
                end
            end
            default: begin
                st_d.state = TX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: TX_IDLE, shift: '0, bit_cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_pop         = start;
    assign timer_restart = start;
    assign line_hi = (st_q.state == TX_SEND) && first_half && st_q.shift[0];
    assign line_lo = (st_q.state == TX_SEND) && first_half && !st_q.shift[0];

    AST_RZ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo)); // R7
    AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == TX_IDLE && !tx_enable) |=> st_q.state == TX_IDLE); // R9
    AST_SEND_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == TX_SEND && !tx_enable) |=> st_q.state != TX_IDLE); // R9
    AST_GAP_BEFORE_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == TX_GAP) |=> st_q.state != TX_SEND); // R8
endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer #(
    parameter int unsigned DEPTH    = 32,
    parameter int unsigned HALF_W   = 16,
    parameter int unsigned DIV_FAST = 10,
    parameter int unsigned DIV_SLOW = 80,
    parameter int unsigned GAP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic [HALF_W-1:0] din,
    input  logic              parity_en,
    input  logic              parity_even,
    input  logic              rate_slow,
    input  logic              tx_enable,
    output logic              line_hi,
    output logic              line_lo,
    output logic              tx_ready,
    output logic              half_flag,
    output logic              full_flag
);
    localparam int unsigned WORD_W = 2 * HALF_W;

    logic [WORD_W-1:0] head;
    logic q_empty, q_pop, restart, first_half, bit_end;

    tx_word_queue #(.DEPTH(DEPTH), .HALF_W(HALF_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_lo    (load_lo),
        .load_hi    (load_hi),
        .din        (din),
        .pop        (q_pop),
        .head       (head),
        .empty      (q_empty),
        .below_half (half_flag),
        .full       (full_flag)
    );

    tx_bit_timer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .rate_slow  (rate_slow),
        .first_half (first_half),
        .bit_end    (bit_end)
    );

    tx_line_shifter #(.WORD_W(WORD_W), .GAP_BITS(GAP_BITS)) u_shifter (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_enable     (tx_enable),
        .q_empty       (q_empty),
        .q_head        (head),
        .parity_en     (parity_en),
        .parity_even   (parity_even),
        .first_half    (first_half),
        .bit_end       (bit_end),
        .q_pop         (q_pop),
        .timer_restart (restart),
        .line_hi       (line_hi),
        .line_lo       (line_lo)
    );

    assign tx_ready = q_empty;
endmodule

// File: tb/sim_a429_tx_serializer.sv
`timescale 1ns/1ps
module sim_a429_tx_serializer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_lo = 1'b0, load_hi = 1'b0;
    logic [15:0] din = '0;
    logic parity_en = 1'b0, parity_even = 1'b0, rate_slow = 1'b0, tx_enable = 1'b0;
    logic line_hi, line_lo, tx_ready, half_flag, full_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    a429_tx_serializer u0 (
        .clk(clk), .rst_n(rst_n), .load_lo(load_lo), .load_hi(load_hi), .din(din),
        .parity_en(parity_en), .parity_even(parity_even), .rate_slow(rate_slow),
        .tx_enable(tx_enable), .line_hi(line_hi), .line_lo(line_lo),
        .tx_ready(tx_ready), .half_flag(half_flag), .full_flag(full_flag)
    );

    typedef struct packed {
        logic [31:0] word;
        logic        pen;
        logic        peven;
        logic        slow;
        logic [31:0] expect_w;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0001, 1'b1, 1'b0, 1'b0, 32'h0000_0001},  // R10 first bit is a one
        '{32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h8000_0000},  // R4 odd
        '{32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0000_0000},  // R4 even
        '{32'h8000_0003, 1'b1, 1'b1, 1'b0, 32'h0000_0003},  // R4 even overrides loaded bit
        '{32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF},  // R5
        '{32'h1234_5678, 1'b0, 1'b0, 1'b1, 32'h1234_5678},  // R5 R6 slow
        '{32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, 32'h7FFF_FFFF},  // R4 odd
        '{32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF}   // R4 even
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_word(input logic [31:0] w);
        @(negedge clk); din = w[15:0]; load_lo = 1'b1;
        @(negedge clk); load_lo = 1'b0; din = w[31:16]; load_hi = 1'b1;
        @(negedge clk); load_hi = 1'b0;
    endtask

    // Waits for a word, decodes it and checks the RZ shape of every bit.
    task automatic receive_word(input int div, input bit drop_en, output logic [31:0] w,
                                output int shape_err, output bit seen);
        int guard;
        w = '0; shape_err = 0; seen = 1'b0; guard = 0;
        while (!(line_hi || line_lo) && guard < 4000) begin
            @(negedge clk); guard++;
        end
        if (!(line_hi || line_lo)) return;
        seen = 1'b1;
        for (int b = 0; b < 32; b++) begin
            if (!(line_hi ^ line_lo)) shape_err++;
            w[b] = line_hi;
            if (drop_en && b == 0) tx_enable = 1'b0;
            for (int c = 1; c < div / 2; c++) begin
                @(negedge clk);
                if (!(line_hi ^ line_lo) || (line_hi != w[b])) shape_err++;
            end
            for (int c = div / 2; c <= div; c++) begin
                @(negedge clk);
                if (c < div && (line_hi || line_lo)) shape_err++;
            end
        end
    endtask

    task automatic quiet_count(input int limit, output int n);
        n = 0;
        while (!(line_hi || line_lo) && n < limit) begin
            @(negedge clk); n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        int se, gap;
        bit seen;

        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 ready", {31'd0, tx_ready}, 32'd1);
        check("R12 half", {31'd0, half_flag}, 32'd1);
        check("R12 full", {31'd0, full_flag}, 32'd0);
        check("R12 lines", {30'd0, line_hi, line_lo}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R1 R4 R5 R6 R7 R10
        for (int i = 0; i < NVEC; i++) begin
            parity_en = VECS[i].pen; parity_even = VECS[i].peven; rate_slow = VECS[i].slow;
            tx_enable = 1'b1;
            load_word(VECS[i].word);
            receive_word(VECS[i].slow ? 80 : 10, 1'b0, w, se, seen);
            check($sformatf("R1 R4 R5 R10 vec%0d word", i), w, VECS[i].expect_w);
            check($sformatf("R6 R7 vec%0d shape errors", i), se, 32'd0);
            quiet_count(2000, gap);
            check($sformatf("R11 vec%0d ready after send", i), {31'd0, tx_ready}, 32'd1);
        end
        rate_slow = 1'b0; parity_en = 1'b0; tx_enable = 1'b0;

        // R9 no start while disabled; R11 and R3 fill behaviour
        load_word({16'h5A00, 16'h0100});
        quiet_count(300, gap);
        check("R9 quiet while disabled", gap, 32'd300);
        check("R11 ready low when queued", {31'd0, tx_ready}, 32'd0);
        for (int k = 1; k < 15; k++) load_word({16'h5A00 | 16'(k), 16'h0100 | 16'(k)});
        @(negedge clk);
        check("R11 half with 15", {31'd0, half_flag}, 32'd1);
        load_word({16'h5A0F, 16'h010F});
        @(negedge clk);
        check("R11 half with 16", {31'd0, half_flag}, 32'd0);
        for (int k = 16; k < 31; k++) load_word({16'h5A00 | 16'(k), 16'h0100 | 16'(k)});
        @(negedge clk);
        check("R3 not full at 31", {31'd0, full_flag}, 32'd0);
        load_word({16'h5A1F, 16'h011F});
        @(negedge clk);
        check("R3 full at 32", {31'd0, full_flag}, 32'd1);
        load_word(32'hDEAD_BEEF);
        @(negedge clk);
        check("R3 still full after drop", {31'd0, full_flag}, 32'd1);

        // drain: R2 order, R8 gap, R3 dropped word absent
        tx_enable = 1'b1;
        for (int k = 0; k < 32; k++) begin
            receive_word(10, 1'b0, w, se, seen);
            check($sformatf("R2 drain word %0d", k), w, {16'h5A00 | 16'(k), 16'h0100 | 16'(k)});
            if (se != 0) check("R7 drain shape", se, 32'd0);
            quiet_count(2000, gap);
            if (k < 31) begin
                n_chk++;
                if (gap < 40) begin
                    n_bad++;
                    $display("FAIL R8 gap actual=%0d expected>=40", gap);
                end
            end
        end
        check("R3 dropped word never sent", gap, 32'd2000);
        check("R11 ready after drain", {31'd0, tx_ready}, 32'd1);

        // R9 word in progress completes after enable drops
        load_word(32'h0F0F_F0F0);
        receive_word(10, 1'b1, w, se, seen);
        check("R9 word completes after disable", w, 32'h0F0F_F0F0);
        check("R9 shape", se, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule